// File: doc/BRIEF.md
# Serial Flash Continuous-Program Sequencer

This block sits inside the slave side of a serial flash and handles the auto-increment program mode. It oversamples the chip-select, serial clock and serial data pins in the system clock domain and assembles bytes MSB first. It decodes the opcode of each frame and keeps the write-enable latch, the mode flag and a ready/busy-on-output option. It issues one byte-program request per step to an array model. The array model reports its busy state back on `wip`.

A host enters the mode with opcode 0xAD, three address bytes and one data byte. Each later step is a new frame with 0xAD and one data byte, programmed at the next address. While the mode is active, only a short list of opcodes is honoured. The mode ends on a write-disable or by itself once the configured top address has been programmed. When ready/busy output is enabled before the mode starts, the serial output shows a live ready level during the mode instead of register data.

Top module: `flash_cp_seq`

## Requirements
- R1: Opcode 0x05 returns the status byte MSB first, repeated for as long as the host clocks; bit 0 follows the `wip` input, bit 1 is the write-enable latch, bit 2 is the mode flag, and bits 7..3 are 0. Each bit is valid on the output before the rising serial clock edge that ends it, with the output enable high.
- R2: A one-byte command (0x06, 0x04, 0x70, 0x80) acts only if chip-select rises right after exactly one whole byte. Opcode 0x06, sent outside the mode, sets the write-enable latch.
- R3: Outside the mode, with the latch set and `wip` low at the opcode, 0xAD followed by a 3-byte address (MSB first) and a data byte gives one program request for that address and data, and the mode is entered. With the latch clear, the frame is ignored.
- R4: An entry address above TOP_ADDR is ignored: no request is made and the mode is not entered.
- R5: In the mode, a frame of 0xAD and one data byte programs the address one above the previous request.
- R6: A 0xAD frame whose opcode arrives while `wip` is high makes no request.
- R7: In the mode, only 0xAD, 0x04, 0x05 and 0x2B are honoured; any other opcode, even with address and data bytes, has no effect.
- R8: In the mode, 0x04 with `wip` low clears the latch and the mode flag; with `wip` high it is ignored.
- R9: A request at TOP_ADDR ends the mode by itself and clears the latch. Later 0xAD step frames make no request.
- R10: Opcode 0x2B returns the SEC_VALUE byte MSB first, also in the mode.
- R11: Opcode 0x70 enables ready/busy output and 0x80 disables it. Both are refused while the mode is active.
- R12: With ready/busy output enabled and the mode active, the output is driven whenever chip-select is low: 0 while `wip` is high, 1 when it is low. The output enable is low whenever chip-select is high.
- R13: Opcode 0x04, sent outside the mode, clears the write-enable latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip-select, active low |
| sclk | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so_d | output | 1 | Serial output data value |
| so_en | output | 1 | Serial output drive enable (0 = high impedance) |
| wip | input | 1 | Busy flag from the array model |
| prog_req | output | 1 | One-cycle byte-program request |
| prog_addr | output | ADDR_W | Address of the request |
| prog_data | output | 8 | Data byte of the request |

## Verification
On every cycle, the assertions check the following: a request never happens without the write-enable latch, never targets an address above the limit, and a step lands one above the previous request. Leaving the mode always leaves the latch clear. The ready/busy option stays frozen while the mode is active, and the address counter never steps past the limit. Opcode filtering, the busy-time refusals, the byte-boundary rule for one-byte commands and the exact serial output levels can only be shown by the bench's frame sequences. The bench checks these with a queue of expected program requests and with status reads.

// File: rtl/flash_cp_pkg.sv
package flash_cp_pkg;

   localparam logic [7:0] OPC_CONT_PROG = 8'hAD;
   localparam logic [7:0] OPC_WR_DIS    = 8'h04;
   localparam logic [7:0] OPC_RD_STAT   = 8'h05;
   localparam logic [7:0] OPC_RD_SEC    = 8'h2B;
   localparam logic [7:0] OPC_WR_EN     = 8'h06;
   localparam logic [7:0] OPC_RB_ON     = 8'h70;
   localparam logic [7:0] OPC_RB_OFF    = 8'h80;

   typedef enum logic [1:0] {
      RD_NONE = 2'd0,
      RD_STAT = 2'd1,
      RD_SEC  = 2'd2
   } rd_src_e;

   // R7: opcodes honoured while the continuous-program mode is active
   function automatic logic mode_allows(input logic [7:0] op);
      return (op == OPC_CONT_PROG) || (op == OPC_WR_DIS) ||
             (op == OPC_RD_STAT)   || (op == OPC_RD_SEC);
   endfunction

endpackage

// File: rtl/cp_spi_front.sv
module cp_spi_front #(
   parameter int SYNC_STAGES = 2,
   parameter int IDX_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             sclk,
   input  logic             si,
   output logic             sel,
   output logic             byte_stb,
   output logic [7:0]       byte_val,
   output logic [IDX_W-1:0] byte_count,
   output logic [2:0]       bit_pos,
   output logic             frame_end,
   output logic             frame_aligned
);

   localparam logic [IDX_W-1:0] IDX_TOP = '1;

   logic cs_s, ck_s, si_s;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("cp_spi_front: SYNC_STAGES must be 0..4");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign cs_s = cs_n;
         assign ck_s = sclk;
         assign si_s = si;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] cs_p, ck_p, si_p;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_p <= '1;
               ck_p <= '0;
               si_p <= '0;
            end else begin
               cs_p <= (cs_p << 1) | SYNC_STAGES'(cs_n);
               ck_p <= (ck_p << 1) | SYNC_STAGES'(sclk);
               si_p <= (si_p << 1) | SYNC_STAGES'(si);
            end
         end
         assign cs_s = cs_p[SYNC_STAGES-1];
         assign ck_s = ck_p[SYNC_STAGES-1];
         assign si_s = si_p[SYNC_STAGES-1];
      end
   endgenerate

   logic       ck_q, cs_q;
   logic [6:0] sr;
   logic       ck_rise;

   assign ck_rise = ck_s & ~ck_q & ~cs_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_q       <= 1'b0;
         cs_q       <= 1'b1;
         sr         <= '0;
         bit_pos    <= '0;
         byte_count <= '0;
      end else begin
         ck_q <= ck_s;
         cs_q <= cs_s;
         if (cs_s) begin
            bit_pos    <= '0;
            byte_count <= '0;
         end else if (ck_rise) begin
            sr      <= {sr[5:0], si_s};
            bit_pos <= bit_pos + 3'd1;
            if (bit_pos == 3'd7 && byte_count != IDX_TOP)
               byte_count <= byte_count + 1'b1;
         end
      end
   end

   assign sel           = ~cs_s;
   assign byte_stb      = ck_rise && (bit_pos == 3'd7);
   assign byte_val      = {sr, si_s};
   assign frame_end     = cs_s & ~cs_q;
   assign frame_aligned = (bit_pos == 3'd0);

endmodule

// File: rtl/cp_addr_ctr.sv
module cp_addr_ctr #(
   parameter int                ADDR_W   = 24,
   parameter logic [ADDR_W-1:0] TOP_ADDR = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              inc,
   output logic [ADDR_W-1:0] addr,
   output logic              at_top
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr <= '0;
      else if (load) addr <= load_val;
      else if (inc)  addr <= addr + ADDR_W'(1);
   end

   assign at_top = (addr == TOP_ADDR);

   // R9: the sequencer never asks for a step beyond the protection limit
   a_r9_no_step_past_limit: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> addr != TOP_ADDR);

endmodule

// File: rtl/cp_cmd_ctrl.sv
module cp_cmd_ctrl
   import flash_cp_pkg::*;
#(
   parameter int                ADDR_W   = 24,
   parameter logic [ADDR_W-1:0] TOP_ADDR = '1,
   parameter int                IDX_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_stb,
   input  logic [7:0]        byte_val,
   input  logic [IDX_W-1:0]  byte_count,
   input  logic              frame_end,
   input  logic              frame_aligned,
   input  logic              wip,
   output logic              wel,
   output logic              cp_mode,
   output logic              rb_en,
   output rd_src_e           rd_src,
   output logic              prog_req,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [7:0]        prog_data
);

   localparam int               ADDR_BYTES = (ADDR_W + 7) / 8;
   localparam int               ACC_W      = ADDR_BYTES * 8;
   localparam logic [IDX_W-1:0] IDX_ONE    = IDX_W'(1);
   localparam logic [IDX_W-1:0] IDX_DATA   = IDX_W'(ADDR_BYTES + 1);

   generate
      if (ADDR_BYTES + 1 >= (1 << IDX_W) - 1) begin : g_bad_idx
         $error("cp_cmd_ctrl: IDX_W too narrow for the address length");
      end
   endgenerate

   logic [7:0]        opcode;
   logic              op_take;
   logic              cp_go;
   logic [ACC_W-1:0]  acc;
   logic              op_legal;
   logic              entry_hit, step_hit, issue;
   logic [ADDR_W-1:0] issue_addr;
   logic [ADDR_W-1:0] ctr_addr;
   logic              ctr_top;

   assign op_legal   = !cp_mode || mode_allows(byte_val);
   assign entry_hit  = byte_stb && cp_go && !cp_mode && (byte_count == IDX_DATA) &&
                       (acc <= ACC_W'(TOP_ADDR));
   assign step_hit   = byte_stb && cp_go && cp_mode && (byte_count == IDX_ONE);
   assign issue      = entry_hit || step_hit;
   assign issue_addr = cp_mode ? ctr_addr : acc[ADDR_W-1:0];

   cp_addr_ctr #(.ADDR_W(ADDR_W), .TOP_ADDR(TOP_ADDR)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (entry_hit),
      .load_val (acc[ADDR_W-1:0] + ADDR_W'(1)),
      .inc      (step_hit && !ctr_top),
      .addr     (ctr_addr),
      .at_top   (ctr_top)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opcode    <= '0;
         op_take   <= 1'b0;
         cp_go     <= 1'b0;
         acc       <= '0;
         wel       <= 1'b0;
         cp_mode   <= 1'b0;
         rb_en     <= 1'b0;
         rd_src    <= RD_NONE;
         prog_req  <= 1'b0;
         prog_addr <= '0;
         prog_data <= '0;
      end else begin
         prog_req <= 1'b0;
         if (byte_stb && byte_count == '0) begin
            opcode  <= byte_val;
            op_take <= op_legal;
            acc     <= '0;
            cp_go   <= op_legal && (byte_val == OPC_CONT_PROG) && !wip && (cp_mode || wel);
            if (op_legal && byte_val == OPC_RD_STAT)     rd_src <= RD_STAT;
            else if (op_legal && byte_val == OPC_RD_SEC) rd_src <= RD_SEC;
            else                                         rd_src <= RD_NONE;
         end else if (byte_stb && cp_go && !cp_mode && byte_count < IDX_DATA) begin
            acc <= (acc << 8) | ACC_W'(byte_val);
         end
         if (issue) begin
            prog_req  <= 1'b1;
            prog_addr <= issue_addr;
            prog_data <= byte_val;
            if (issue_addr == TOP_ADDR) begin
               cp_mode <= 1'b0;
               wel     <= 1'b0;
            end else begin
               cp_mode <= 1'b1;
            end
         end
         if (frame_end) begin
            rd_src  <= RD_NONE;
            cp_go   <= 1'b0;
            op_take <= 1'b0;
            if (op_take && frame_aligned && byte_count == IDX_ONE) begin
               case (opcode)
                  OPC_WR_EN:  wel <= 1'b1;
                  OPC_WR_DIS: begin
                     if (!cp_mode) begin
                        wel <= 1'b0;
                     end else if (!wip) begin
                        wel     <= 1'b0;
                        cp_mode <= 1'b0;
                     end
                  end
                  OPC_RB_ON:  rb_en <= 1'b1;
                  OPC_RB_OFF: rb_en <= 1'b0;
                  default: ;
               endcase
            end
         end
      end
   end

   // checker state: address of the previous program request
   logic [ADDR_W-1:0] chk_last;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        chk_last <= '0;
      else if (prog_req) chk_last <= prog_addr;
   end

   // R3: no request is made unless the write-enable latch was set
   a_r3_req_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> $past(wel));

   // R4: requests stay inside the unprotected range
   a_r4_req_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> prog_addr <= TOP_ADDR);

   // R5: a step inside the mode targets the next address
   a_r5_step_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req && $past(cp_mode) |-> prog_addr == chk_last + ADDR_W'(1));

   // R8 and R9: leaving the mode always leaves the latch clear
   a_r8_exit_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cp_mode) |-> !wel);

   // R11: the ready/busy option cannot change while the mode is active
   a_r11_rb_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      cp_mode && $past(cp_mode) |-> rb_en == $past(rb_en));

endmodule

// File: rtl/cp_so_mux.sv
module cp_so_mux
   import flash_cp_pkg::*;
#(
   parameter logic [7:0] SEC_VALUE = 8'hC3
) (
   input  logic       sel,
   input  logic       rb_en,
   input  logic       cp_mode,
   input  logic       wip,
   input  logic       wel,
   input  rd_src_e    rd_src,
   input  logic [2:0] bit_pos,
   output logic       so_d,
   output logic       so_en
);

   logic [7:0] status;
   assign status = {5'b0, cp_mode, wel, wip};

   always_comb begin
      so_en = 1'b0;
      so_d  = 1'b0;
      if (sel) begin
         if (rb_en && cp_mode) begin
            so_en = 1'b1;
            so_d  = ~wip;
         end else if (rd_src == RD_STAT) begin
            so_en = 1'b1;
            so_d  = status[~bit_pos];
         end else if (rd_src == RD_SEC) begin
            so_en = 1'b1;
            so_d  = SEC_VALUE[~bit_pos];
         end
      end
   end

endmodule

// File: rtl/flash_cp_seq.sv
module flash_cp_seq
   import flash_cp_pkg::*;
#(
   parameter int                ADDR_W      = 24,
   parameter logic [ADDR_W-1:0] TOP_ADDR    = 24'h000FFF,
   parameter logic [7:0]        SEC_VALUE   = 8'hC3,
   parameter int                SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              si,
   output logic              so_d,
   output logic              so_en,
   input  logic              wip,
   output logic              prog_req,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [7:0]        prog_data
);

   localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
   localparam int IDX_W      = $clog2(ADDR_BYTES + 3);

   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("flash_cp_seq: ADDR_W must be 8..32");
      end
   endgenerate

   logic             sel, byte_stb, frame_end, frame_aligned;
   logic [7:0]       byte_val;
   logic [IDX_W-1:0] byte_count;
   logic [2:0]       bit_pos;
   logic             wel, cp_mode, rb_en;
   rd_src_e          rd_src;

   cp_spi_front #(.SYNC_STAGES(SYNC_STAGES), .IDX_W(IDX_W)) u_front (
      .clk           (clk),
      .rst_n         (rst_n),
      .cs_n          (cs_n),
      .sclk          (sclk),
      .si            (si),
      .sel           (sel),
      .byte_stb      (byte_stb),
      .byte_val      (byte_val),
      .byte_count    (byte_count),
      .bit_pos       (bit_pos),
      .frame_end     (frame_end),
      .frame_aligned (frame_aligned)
   );

   cp_cmd_ctrl #(.ADDR_W(ADDR_W), .TOP_ADDR(TOP_ADDR), .IDX_W(IDX_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .byte_stb      (byte_stb),
      .byte_val      (byte_val),
      .byte_count    (byte_count),
      .frame_end     (frame_end),
      .frame_aligned (frame_aligned),
      .wip           (wip),
      .wel           (wel),
      .cp_mode       (cp_mode),
      .rb_en         (rb_en),
      .rd_src        (rd_src),
      .prog_req      (prog_req),
      .prog_addr     (prog_addr),
      .prog_data     (prog_data)
   );

   cp_so_mux #(.SEC_VALUE(SEC_VALUE)) u_so (
      .sel     (sel),
      .rb_en   (rb_en),
      .cp_mode (cp_mode),
      .wip     (wip),
      .wel     (wel),
      .rd_src  (rd_src),
      .bit_pos (bit_pos),
      .so_d    (so_d),
      .so_en   (so_en)
   );

   // R12: the output stays released while the sampled chip-select is high
   a_r12_released_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |-> !so_en);

   // R12: with the option on inside the mode, the output carries the ready level
   a_r12_ready_level: assert property (@(posedge clk) disable iff (!rst_n)
      sel && rb_en && cp_mode |-> so_en && (so_d == !wip));

endmodule

// File: tb/flash_cp_seq_test.sv
module flash_cp_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int HALF_SCK   = 4;
   localparam int BUSY_CYC   = 300;
   localparam int ADDR_W     = 24;
   localparam logic [ADDR_W-1:0] TOP = 24'h000FFF;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cs_n = 1'b1;
   logic              sclk = 1'b0;
   logic              si = 1'b0;
   logic              so_d, so_en;
   logic              wip;
   logic              prog_req;
   logic [ADDR_W-1:0] prog_addr;
   logic [7:0]        prog_data;

   int checks = 0;
   int errors = 0;
   int busy_cnt = 0;
   logic [31:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_cp_seq #(.ADDR_W(ADDR_W), .TOP_ADDR(TOP), .SEC_VALUE(8'hC3), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
      .so_d(so_d), .so_en(so_en), .wip(wip),
      .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data)
   );

   // behavioural array: busy for a fixed time after each request
   assign wip = (busy_cnt != 0);
   always @(posedge clk) begin
      if (!rst_n)              busy_cnt <= 0;
      else if (prog_req)       busy_cnt <= BUSY_CYC;
      else if (busy_cnt != 0)  busy_cnt <= busy_cnt - 1;
   end

   // monitor: every request must match the next expected item
   always @(posedge clk) begin
      if (rst_n && prog_req) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R3/R5/R6/R7 unexpected request got %h:%h exp none", prog_addr, prog_data);
         end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            if ({prog_addr, prog_data} !== e) begin
               errors++;
               $display("FAIL R3/R5 request got %h exp %h", {prog_addr, prog_data}, e);
            end
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic sel_on();
      @(negedge clk) cs_n = 1'b0;
      repeat (HALF_SCK) @(negedge clk);
   endtask

   task automatic sel_off();
      @(negedge clk);
      sclk = 1'b0;
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic drove);
      drove = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         sclk = 1'b0;
         si   = tx[i];
         repeat (HALF_SCK) @(negedge clk);
         rx[i] = so_d;
         drove = drove & so_en;
         sclk = 1'b1;
         repeat (HALF_SCK) @(negedge clk);
      end
   endtask

   task automatic cmd(input logic [7:0] op);
      logic [7:0] r;
      logic d;
      sel_on();
      xfer(op, r, d);
      sel_off();
   endtask

   task automatic read_reg(input logic [7:0] op, output logic [7:0] val, output logic drove);
      logic [7:0] r;
      logic d;
      sel_on();
      xfer(op, r, d);
      xfer(8'h00, val, drove);
      sel_off();
   endtask

   task automatic chk_status(input string tag, input logic [7:0] exp);
      logic [7:0] v;
      logic d;
      read_reg(8'h05, v, d);
      check(tag, {24'h0, v}, {24'h0, exp});
      check({tag, " drive"}, {31'h0, d}, 32'h1);
   endtask

   task automatic prog_entry(input logic [23:0] a, input logic [7:0] dt, input logic expect_req);
      logic [7:0] r;
      logic d;
      if (expect_req) exp_q.push_back({a, dt});
      sel_on();
      xfer(8'hAD, r, d);
      xfer(a[23:16], r, d);
      xfer(a[15:8], r, d);
      xfer(a[7:0], r, d);
      xfer(dt, r, d);
      sel_off();
   endtask

   task automatic prog_step(input logic [7:0] dt, input logic expect_req, input logic [23:0] a);
      logic [7:0] r;
      logic d;
      if (expect_req) exp_q.push_back({a, dt});
      sel_on();
      xfer(8'hAD, r, d);
      xfer(dt, r, d);
      sel_off();
   endtask

   task automatic wait_idle();
      while (busy_cnt != 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired got running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [7:0] v;
      logic d;
      logic [7:0] r;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // reset state
      check("R12 reset output released", {31'h0, so_en}, 32'h0);
      chk_status("R1 reset status", 8'h00);

      // R3: entry without write enable is ignored
      prog_entry(24'h000100, 8'h11, 1'b0);
      chk_status("R3 no entry without latch", 8'h00);

      // R2: write enable sets the latch
      cmd(8'h06);
      chk_status("R2 write enable", 8'h02);

      // R2: write disable followed by an extra byte is not a one-byte command
      sel_on();
      xfer(8'h04, r, d);
      xfer(8'h00, r, d);
      sel_off();
      chk_status("R2 two-byte frame ignored", 8'h02);

      // R3: proper entry; status read while busy shows WIP, latch and mode
      prog_entry(24'h000100, 8'hA5, 1'b1);
      chk_status("R3 R1 busy status after entry", 8'h07);
      wait_idle();
      chk_status("R1 idle status in mode", 8'h06);

      // R11: ready/busy enable refused in mode; R7: page-program style frame ignored
      cmd(8'h70);
      cmd(8'h06);
      sel_on();
      xfer(8'h02, r, d);
      xfer(8'h00, r, d);
      xfer(8'h01, r, d);
      xfer(8'h02, r, d);
      xfer(8'h33, r, d);
      sel_off();
      chk_status("R11 R7 status unchanged in mode", 8'h06);

      // R5: next step; R6: step while busy ignored; R8: disable while busy ignored
      prog_step(8'h5A, 1'b1, 24'h000101);
      prog_step(8'h77, 1'b0, 24'h0);
      cmd(8'h04);
      wait_idle();
      chk_status("R6 R8 mode kept after busy commands", 8'h06);

      // R10: security byte readable in mode
      read_reg(8'h2B, v, d);
      check("R10 security byte", {24'h0, v}, 32'h000000C3);

      // R5: another step, then R8: disable ends the mode
      prog_step(8'h3C, 1'b1, 24'h000102);
      wait_idle();
      cmd(8'h04);
      chk_status("R8 disable ends mode", 8'h00);
      prog_step(8'h44, 1'b0, 24'h0);

      // R13: disable outside mode clears latch
      cmd(8'h06);
      cmd(8'h04);
      chk_status("R13 disable outside mode", 8'h00);

      // R4: entry above limit ignored
      cmd(8'h06);
      prog_entry(24'h001000, 8'hEE, 1'b0);
      chk_status("R4 entry above limit", 8'h02);

      // R9: programming the top address ends the mode
      prog_entry(24'h000FFE, 8'h01, 1'b1);
      wait_idle();
      prog_step(8'h02, 1'b1, 24'h000FFF);
      wait_idle();
      chk_status("R9 auto exit at limit", 8'h00);
      prog_step(8'h03, 1'b0, 24'h0);

      // R11/R12: ready/busy on output
      cmd(8'h06);
      cmd(8'h70);
      prog_entry(24'h000200, 8'h99, 1'b1);
      sel_on();
      check("R12 busy level drive", {31'h0, so_en}, 32'h1);
      check("R12 busy level", {31'h0, so_d}, 32'h0);
      wait_idle();
      check("R12 ready level", {31'h0, so_d}, 32'h1);
      sel_off();
      check("R12 released after deselect", {31'h0, so_en}, 32'h0);
      cmd(8'h80);
      sel_on();
      check("R11 disable refused in mode", {31'h0, so_d & so_en}, 32'h1);
      sel_off();
      cmd(8'h04);
      chk_status("R8 R11 exit with option on", 8'h00);
      cmd(8'h80);
      cmd(8'h06);
      prog_entry(24'h000300, 8'h55, 1'b1);
      wait_idle();
      chk_status("R11 option off restores status", 8'h06);
      cmd(8'h04);

      repeat (10) @(negedge clk);
      check("R7 all expected requests seen", exp_q.size(), 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule